// File: doc/BRIEF.md
# Boot-Script Register Write Executor

This block runs one kind of boot-script command: a sized or bit-field store to memory, followed by a programmed pause. Script words arrive one at a time on a 32-bit valid/ready input. When the command's opcode word is seen, the block collects four more words: a type word, a byte address, a 32-bit data word and a delay count. It then issues the store on a memory port that has separate read and write strobes.

The type word selects one of three store widths: a byte, a halfword or a full word. It can also select a bit-field update. A bit-field update reads the target word, replaces only the selected bit range, and writes the result back.

After the store, the block holds off the next command for the programmed number of cycles. Malformed commands and unknown opcodes set a sticky error flag and cause no memory access.

Top module: `cfgwr_exec`

## Requirements
- R1: The word 0x58535907 received while idle starts a command. The next four accepted words are taken in order as the type word, the target byte address, the data word and the delay count. `busy` is high from the cycle after the opcode is accepted.
- R2: Any other word received while idle is consumed. It sets `err`, causes no read and no write, and leaves `busy` low.
- R3: Size code 0 (type bits 7:0) is a byte store. `mem_wr_be` is 1 shifted left by address bits 1:0. Data bits 7:0 appear in every byte lane of `mem_wr_data`.
- R4: Size code 1 is a halfword store with data bits 15:0. The byte enables are 0011 when address bit 1 is 0 and 1100 when it is 1. If address bit 0 is set, `err` is raised and nothing is written.
- R5: Size code 2 stores the full data word with all byte enables set. Every store goes to the address with its two low bits cleared.
- R6: Size codes 3 and 4 are a bit-field update. The low field bit is type bits 15:8 and the high field bit is type bits 23:16. The block reads the word with `mem_rd_en`; the read data is valid on the following cycle. On that following cycle it writes the word back with all byte enables set. Bits low..high take the data word shifted left by low. All other bits keep their read value.
- R7: In a bit-field update, a high bit below the low bit, or either bit position above 31, raises `err`. No read and no write take place.
- R8: Nonzero type bits 31:24, or a size code from 5 to 255, raise `err` with no read and no write.
- R9: Let W be the cycle in which `mem_wr_en` is high and D the delay count. `in_ready` and `busy` return high, and low respectively, in cycle W+D+1. With D = 0 this is the cycle right after the store.
- R10: `err` stays set until reset. After a rejected command the block returns to idle and executes the next valid command normally.
- R11: After reset, `busy` and `err` are low, `in_ready` is high, and neither memory strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Script word present |
| in_data | input | 32 | Script word |
| in_ready | output | 1 | Block takes a word this cycle when valid |
| mem_rd_en | output | 1 | Read strobe for a bit-field update |
| mem_rd_addr | output | 32 | Word-aligned read address |
| mem_rd_data | input | 32 | Read data, valid the cycle after the strobe |
| mem_wr_en | output | 1 | Write strobe |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write data, lane-placed |
| mem_wr_be | output | 4 | Byte enables |
| busy | output | 1 | Command in progress, including the delay |
| err | output | 1 | Sticky error flag |

## Verification
For a plain store, the write strobe appears one cycle after the last argument is accepted. For a bit-field update, the read strobe appears in that cycle and the write strobe one cycle later. The bench's memory model registers the read data on the strobe edge, which matches the one-cycle read latency the block expects. The model also stamps the cycle of each write. The bench then finds the first cycle in which `in_ready` is high again and checks that it is exactly D+1 cycles after the stamped write. Memory contents and error state are sampled on falling edges, only after `in_ready` has returned, so each registered result has settled before it is compared.

// File: rtl/cfgwr_pkg.sv
package cfgwr_pkg;

    localparam int WORD_W = 32;
    localparam int BE_W   = WORD_W / 8;
    localparam int OFF_W  = $clog2(BE_W);
    localparam int POS_W  = $clog2(WORD_W);
    localparam int NARG   = 4;
    localparam int IDX_W  = $clog2(NARG);

    localparam logic [WORD_W-1:0] OPC_STORE = 32'h5853_5907;

    localparam logic [7:0] SZ_BYTE    = 8'd0;
    localparam logic [7:0] SZ_HALF    = 8'd1;
    localparam logic [7:0] SZ_WORD    = 8'd2;
    localparam logic [7:0] SZ_FIELD_A = 8'd3;
    localparam logic [7:0] SZ_FIELD_B = 8'd4;
    localparam logic [7:0] POS_LIMIT  = 8'(WORD_W);

    // argument slots in arrival order
    localparam int ARG_KIND  = 0;
    localparam int ARG_ADDR  = 1;
    localparam int ARG_DATA  = 2;
    localparam int ARG_DELAY = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARGS,
        ST_EXEC,
        ST_MERGE,
        ST_WAIT
    } st_e;

    typedef struct packed {
        logic [7:0] rsvd;
        logic [7:0] hi;
        logic [7:0] lo;
        logic [7:0] size;
    } kind_word_t;

    typedef struct packed {
        logic [WORD_W-1:0] kind;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] data;
        logic [WORD_W-1:0] delay;
    } cmd_t;

    function automatic logic [WORD_W-1:0] field_mask(
        input logic [POS_W-1:0] lo,
        input logic [POS_W-1:0] hi
    );
        logic [WORD_W-1:0] up, dn;
        up = {WORD_W{1'b1}} << lo;
        dn = {WORD_W{1'b1}} >> (POS_W'(WORD_W - 1) - hi);
        return up & dn;
    endfunction

endpackage

// File: rtl/cfgwr_argcap.sv
module cfgwr_argcap
    import cfgwr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        cap_en,
    input  logic [IDX_W-1:0]            cap_idx,
    input  logic [WORD_W-1:0]           cap_word,
    output logic [NARG-1:0][WORD_W-1:0] args
);

    for (genvar g = 0; g < NARG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                args[g] <= '0;
            end else if (cap_en && cap_idx == IDX_W'(g)) begin
                args[g] <= cap_word;
            end
        end
    end

endmodule

// File: rtl/cfgwr_lane.sv
module cfgwr_lane
    import cfgwr_pkg::*;
(
    input  logic [WORD_W-1:0] kind,
    input  logic [WORD_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    input  logic [WORD_W-1:0] rd_data,
    output logic              bad,
    output logic              field,
    output logic [WORD_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [BE_W-1:0]   wr_be
);

    kind_word_t        kw;
    logic [OFF_W-1:0]  off;
    logic [WORD_W-1:0] mask;

    assign kw      = kind_word_t'(kind);
    assign off     = addr[OFF_W-1:0];
    assign wr_addr = {addr[WORD_W-1:OFF_W], {OFF_W{1'b0}}};
    assign mask    = field_mask(kw.lo[POS_W-1:0], kw.hi[POS_W-1:0]);

    always_comb begin
        field   = (kw.size == SZ_FIELD_A) || (kw.size == SZ_FIELD_B);
        bad     = (kw.rsvd != 8'd0) || (kw.size > SZ_FIELD_B);
        wr_data = data;
        wr_be   = {BE_W{1'b1}};
        case (kw.size)
            SZ_BYTE: begin
                wr_data = {BE_W{data[7:0]}};
                wr_be   = BE_W'(1) << off;
            end
            SZ_HALF: begin
                wr_data = {(BE_W/2){data[15:0]}};
                wr_be   = BE_W'(3) << {off[OFF_W-1:1], 1'b0};
                bad     = bad | off[0];
            end
            SZ_WORD: begin
                wr_data = data;
            end
            default: begin
                if (field) begin
                    if (kw.lo >= POS_LIMIT || kw.hi >= POS_LIMIT || kw.hi < kw.lo) begin
                        bad = 1'b1;
                    end
                    wr_data = (rd_data & ~mask)
                            | ((data << kw.lo[POS_W-1:0]) & mask);
                end
            end
        endcase
    end

endmodule

// File: rtl/cfgwr_delay.sv
module cfgwr_delay #(
    parameter int DLY_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    output logic             last
);

    logic [DLY_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - DLY_W'(1);
        end
    end

    assign last = (cnt == DLY_W'(1));

endmodule

// File: rtl/cfgwr_exec.sv
module cfgwr_exec
    import cfgwr_pkg::*;
#(
    parameter int DLY_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic        mem_rd_en,
    output logic [31:0] mem_rd_addr,
    input  logic [31:0] mem_rd_data,
    output logic        mem_wr_en,
    output logic [31:0] mem_wr_addr,
    output logic [31:0] mem_wr_data,
    output logic [3:0]  mem_wr_be,
    output logic        busy,
    output logic        err
);

    st_e                        state;
    logic [IDX_W-1:0]           arg_idx;
    logic [NARG-1:0][WORD_W-1:0] args;
    cmd_t                       cmd;
    logic                       accept;
    logic                       bad, field;
    logic [WORD_W-1:0]          lane_addr;
    logic                       do_store, dly_load, dly_last, zero_delay;

    assign cmd.kind  = args[ARG_KIND];
    assign cmd.addr  = args[ARG_ADDR];
    assign cmd.data  = args[ARG_DATA];
    assign cmd.delay = args[ARG_DELAY];

    assign in_ready   = (state == ST_IDLE) || (state == ST_ARGS);
    assign accept     = in_valid && in_ready;
    assign busy       = (state != ST_IDLE);
    assign zero_delay = (cmd.delay[DLY_W-1:0] == '0);

    cfgwr_argcap u_cap (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (accept && state == ST_ARGS),
        .cap_idx  (arg_idx),
        .cap_word (in_data),
        .args     (args)
    );

    cfgwr_lane u_lane (
        .kind    (cmd.kind),
        .addr    (cmd.addr),
        .data    (cmd.data),
        .rd_data (mem_rd_data),
        .bad     (bad),
        .field   (field),
        .wr_addr (lane_addr),
        .wr_data (mem_wr_data),
        .wr_be   (mem_wr_be)
    );

    assign do_store  = ((state == ST_EXEC) && !bad && !field) || (state == ST_MERGE);
    assign dly_load  = do_store;
    assign mem_wr_en = do_store;
    assign mem_rd_en = (state == ST_EXEC) && !bad && field;
    assign mem_wr_addr = lane_addr;
    assign mem_rd_addr = lane_addr;

    cfgwr_delay #(.DLY_W(DLY_W)) u_dly (
        .clk      (clk),
        .rst      (rst),
        .load     (dly_load),
        .load_val (cmd.delay[DLY_W-1:0]),
        .last     (dly_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            arg_idx <= '0;
            err     <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (in_data == OPC_STORE) begin
                            state   <= ST_ARGS;
                            arg_idx <= '0;
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                ST_ARGS: begin
                    if (accept) begin
                        arg_idx <= arg_idx + IDX_W'(1);
                        if (arg_idx == IDX_W'(NARG - 1)) begin
                            state <= ST_EXEC;
                        end
                    end
                end
                ST_EXEC: begin
                    if (bad) begin
                        err   <= 1'b1;
                        state <= ST_IDLE;
                    end else if (field) begin
                        state <= ST_MERGE;
                    end else begin
                        state <= zero_delay ? ST_IDLE : ST_WAIT;
                    end
                end
                ST_MERGE: begin
                    state <= zero_delay ? ST_IDLE : ST_WAIT;
                end
                ST_WAIT: begin
                    if (dly_last) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgwr_exec_chk.sv
module cfgwr_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_ready,
    input logic        busy,
    input logic        err,
    input logic        mem_rd_en,
    input logic        mem_wr_en,
    input logic [31:0] mem_wr_addr,
    input logic [3:0]  mem_wr_be
);

    AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en |=> mem_wr_en); // R6

    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err |=> err); // R10

    AST_BE_SHAPE: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> ($countones(mem_wr_be) == 1 || $countones(mem_wr_be) == 2
                       || $countones(mem_wr_be) == 4)); // R3

    AST_HALF_LANES: assert property (@(posedge clk) disable iff (rst)
        (mem_wr_en && $countones(mem_wr_be) == 2) |-> (mem_wr_be == 4'b0011 || mem_wr_be == 4'b1100)); // R4

    AST_WR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (mem_wr_addr[1:0] == 2'b00)); // R5

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> in_ready); // R9

    AST_WR_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> (busy && !in_ready)); // R9

    AST_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> (!$past(mem_wr_en) && !mem_wr_en)); // R7

endmodule

bind cfgwr_exec cfgwr_exec_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_ready    (in_ready),
    .busy        (busy),
    .err         (err),
    .mem_rd_en   (mem_rd_en),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_be   (mem_wr_be)
);

// File: tb/cfgwr_exec_tb_top.sv
`timescale 1ns/1ps
module cfgwr_exec_tb_top;

    localparam logic [31:0] OPC = 32'h5853_5907;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_ready;
    logic        mem_rd_en, mem_wr_en;
    logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
    logic [31:0] rd_q = '0;
    logic [3:0]  mem_wr_be;
    logic        busy, err;

    always #10 clk = ~clk;

    cfgwr_exec dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(rd_q),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_wr_be(mem_wr_be), .busy(busy), .err(err)
    );

    // memory model and cycle stamps
    logic [31:0] mem [16];
    int   cyc = 0, wr_cnt = 0, rd_cnt = 0, wr_cyc = 0;
    logic        pre_en = 1'b0;
    logic [3:0]  pre_idx = '0;
    logic [31:0] pre_val = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (pre_en) mem[pre_idx] <= pre_val;
        if (mem_wr_en) begin
            for (int b = 0; b < 4; b++)
                if (mem_wr_be[b]) mem[mem_wr_addr[5:2]][8*b +: 8] <= mem_wr_data[8*b +: 8];
            wr_cnt <= wr_cnt + 1;
            wr_cyc <= cyc;
        end
        if (mem_rd_en) begin
            rd_q   <= mem[mem_rd_addr[5:2]];
            rd_cnt <= rd_cnt + 1;
        end
    end

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic preload(input logic [3:0] idx, input logic [31:0] val);
        pre_en = 1'b1; pre_idx = idx; pre_val = val;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        in_valid = 1'b1; in_data = w;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_cmd(input logic [31:0] ty, ad, da, dl, output int ready_cyc);
        send_word(OPC);
        send_word(ty);
        send_word(ad);
        send_word(da);
        send_word(dl);
        while (!in_ready) @(negedge clk);
        ready_cyc = cyc;
    endtask

    typedef struct packed {
        logic [31:0] ty, ad, da, dl, pre, ex;
    } vec_t;

    localparam vec_t VECS [10] = '{
        '{32'h0000_0000, 32'h0000_0011, 32'hABCD_EF5A, 32'd0, 32'h1122_3344, 32'h1122_5A44},
        '{32'h0000_0000, 32'h0000_0013, 32'h0000_00C3, 32'd3, 32'h0000_0000, 32'hC300_0000},
        '{32'h0000_0001, 32'h0000_0022, 32'h1234_BEEF, 32'd2, 32'hAAAA_AAAA, 32'hBEEF_AAAA},
        '{32'h0000_0001, 32'h0000_0020, 32'hFFFF_0102, 32'd0, 32'hAAAA_AAAA, 32'hAAAA_0102},
        '{32'h0000_0002, 32'h0000_0031, 32'hCAFE_F00D, 32'd5, 32'h0000_0000, 32'hCAFE_F00D},
        '{32'h000B_0403, 32'h0000_0008, 32'hFFFF_FFAB, 32'd1, 32'h1234_5678, 32'h1234_5AB8},
        '{32'h0000_0004, 32'h0000_000C, 32'h0000_0000, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFE},
        '{32'h001F_1F03, 32'h0000_003C, 32'h0000_0001, 32'd2, 32'h0000_0000, 32'h8000_0000},
        '{32'h001F_0004, 32'h0000_0004, 32'h89AB_CDEF, 32'd0, 32'h0000_0000, 32'h89AB_CDEF},
        '{32'h0017_1003, 32'h0000_0018, 32'h0000_00FF, 32'd4, 32'h1234_5678, 32'h12FF_5678}
    };

    task automatic bad_cmd(input logic [31:0] ty, ad, input string tag);
        int rc;
        int wc0, rc0;
        do_reset();
        preload(ad[5:2], 32'h5555_5555);
        wc0 = wr_cnt; rc0 = rd_cnt;
        run_cmd(ty, ad, 32'hFFFF_FFFF, 32'd0, rc);
        @(negedge clk);
        check(err === 1'b1, {tag, " err set"}, 32'(err), 32'd1);
        check(busy === 1'b0, {tag, " idle after reject"}, 32'(busy), 32'd0);
        check(wr_cnt == wc0 && rd_cnt == rc0, {tag, " no access"}, 32'(wr_cnt - wc0 + rd_cnt - rc0), 32'd0);
        check(mem[ad[5:2]] === 32'h5555_5555, {tag, " word unchanged"}, mem[ad[5:2]], 32'h5555_5555);
    endtask

    initial begin
        int rcyc, wc0, rc0;
        string tag;
        do_reset();
        // R11 reset state
        check(busy === 1'b0 && err === 1'b0, "R11 busy/err after reset", {30'd0, busy, err}, 32'd0);
        check(in_ready === 1'b1, "R11 ready after reset", 32'(in_ready), 32'd1);
        check(mem_wr_en === 1'b0 && mem_rd_en === 1'b0, "R11 strobes idle", {30'd0, mem_wr_en, mem_rd_en}, 32'd0);

        // table walk: R3 R4 R5 R6 R9
        for (int i = 0; i < 10; i++) begin
            logic [7:0] sz;
            sz = VECS[i].ty[7:0];
            tag = (sz == 8'd0) ? "R3" : (sz == 8'd1) ? "R4" : (sz == 8'd2) ? "R5" : "R6";
            preload(VECS[i].ad[5:2], VECS[i].pre);
            wc0 = wr_cnt; rc0 = rd_cnt;
            run_cmd(VECS[i].ty, VECS[i].ad, VECS[i].da, VECS[i].dl, rcyc);
            check(mem[VECS[i].ad[5:2]] === VECS[i].ex, {tag, " stored word"}, mem[VECS[i].ad[5:2]], VECS[i].ex);
            check(wr_cnt - wc0 == 1, {tag, " single write"}, 32'(wr_cnt - wc0), 32'd1);
            check(rd_cnt - rc0 == ((sz >= 8'd3) ? 1 : 0), "R6 read count", 32'(rd_cnt - rc0),
                  (sz >= 8'd3) ? 32'd1 : 32'd0);
            check(rcyc - wr_cyc - 1 == int'(VECS[i].dl), "R9 ready delay", 32'(rcyc - wr_cyc - 1), VECS[i].dl);
            check(busy === 1'b0 && err === 1'b0, {tag, " clean finish"}, {30'd0, busy, err}, 32'd0);
        end

        // R1 busy right after opcode
        do_reset();
        send_word(OPC);
        check(busy === 1'b1 && err === 1'b0, "R1 busy after opcode", {30'd0, busy, err}, 32'd2);
        send_word(32'h0000_0002);
        send_word(32'h0000_0000);
        send_word(32'h0BAD_F00D);
        send_word(32'd0);
        while (!in_ready) @(negedge clk);
        check(mem[0] === 32'h0BAD_F00D, "R1 argument order", mem[0], 32'h0BAD_F00D);

        // R2 unknown opcode
        do_reset();
        wc0 = wr_cnt; rc0 = rd_cnt;
        send_word(32'hDEAD_BEEF);
        check(err === 1'b1, "R2 err on unknown word", 32'(err), 32'd1);
        check(busy === 1'b0 && wr_cnt == wc0 && rd_cnt == rc0, "R2 no activity", {31'd0, busy}, 32'd0);

        // R4 odd halfword, then R10 recovery
        bad_cmd(32'h0000_0001, 32'h0000_0021, "R4 odd halfword");
        preload(4'd2, 32'h0);
        run_cmd(32'h0000_0002, 32'h0000_0008, 32'h7777_1234, 32'd0, rcyc);
        check(mem[2] === 32'h7777_1234, "R10 next command runs after reject", mem[2], 32'h7777_1234);
        check(err === 1'b1, "R10 err sticky", 32'(err), 32'd1);

        // R7 field range faults
        bad_cmd(32'h0003_0803, 32'h0000_0010, "R7 stop below start");
        bad_cmd(32'h0021_2004, 32'h0000_0014, "R7 position above 31");
        // R8 reserved encodings
        bad_cmd(32'h0100_0002, 32'h0000_0018, "R8 reserved high byte");
        bad_cmd(32'h0000_0005, 32'h0000_001C, "R8 reserved size code");

        do_reset();
        check(err === 1'b0, "R10 err cleared only by reset", 32'(err), 32'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule